// File: doc/BRIEF.md
# ROM Sample Playback Sequencer

This block plays one stored sound effect at a time out of a byte-wide ROM. A one-cycle play strobe carries a 3-bit sound code. When the block is idle and the code names a stored sound, a running flag is raised. From then on, at every sample tick the block reads two consecutive ROM bytes and joins them into a 16-bit sample. It hands that sample to a downstream DAC serializer with a one-cycle valid strobe.

The ROM is read combinationally: the data for an address arrives in the same cycle the address is driven. The byte address is built from three fields. The upper three bits pick one of eight sections, the middle bits give the sample index, and bit 0 picks the byte within the sample. Codes 0 to 3 name short sounds that each fill one section. Codes 4 and 5 name long sounds that each fill two adjacent sections, so their sample index carries into the section field. A clock-enable divider paces the samples; with the default settings this gives 16 kHz.

Top module: `rom_playback_seq`

## Requirements
- R1: After reset, `busy_o` and `sample_vld_o` are both low.
- R2: A play strobe with a code from 0 to 5, sampled at a clock edge while `busy_o` is low, makes `busy_o` high from that edge on.
- R3: Each sample is fetched with two reads on consecutive cycles. The first read is at the even byte address {section, index, 0} and the second is at the following odd address.
- R4: Samples are little-endian. `sample_o[7:0]` is the byte read at the even address and `sample_o[15:8]` is the byte read at the odd address. Both bytes are valid while `sample_vld_o` is high.
- R5: `sample_vld_o` is high for exactly one cycle per sample. Within one sound, consecutive pulses are exactly TICK_DIV cycles apart.
- R6: The first `sample_vld_o` pulse of a sound is high in the cycle that starts TICK_DIV+2 clock edges after the accepting edge.
- R7: Codes 0 to 3 play 2^IDX_W samples from the section equal to the code, at indices 0, 1, 2 and so on.
- R8: Code 4 plays 2^(IDX_W+1) samples starting at section 4, and code 5 plays the same number starting at section 6. The index carries into the next section.
- R9: A play strobe that arrives while `busy_o` is high is ignored. The running sound continues unchanged.
- R10: A play strobe with code 6 or 7 is ignored: `busy_o` stays low and no sample is produced.
- R11: `busy_o` falls at the clock edge that ends the final sample's valid pulse. A later play of any sound starts again from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| play_i | input | 1 | One-cycle play request |
| sound_i | input | 3 | Sound code sampled with `play_i` |
| rom_addr_o | output | IDX_W+4 | Byte address to the ROM (19 bits by default) |
| rom_data_i | input | 8 | ROM byte, valid in the same cycle as the address |
| sample_o | output | 16 | Assembled sample, held between pulses |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |
| busy_o | output | 1 | Running flag, high while a sound plays |

## Verification
The bench drives a ROM model whose byte value is a hash of its address. Every section and byte position therefore returns a different value. This means a swapped byte order, a wrong section or an off-by-one index produces a wrong sample, not merely a wrong count. Each short code and both long codes are played in turn. The long ones tell whether the index carries into the section field. The short ones tell whether a sound stops after exactly one section. A replay of the same code checks that the index restarts from zero. Requests that arrive mid-sound, and requests with the two unused codes, are checked for leaving the sample stream and the running flag untouched.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int SEC_W    = 3;
  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;
  localparam int CODE_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LO,
    ST_HI,
    ST_EMIT
  } pb_state_e;

  typedef struct packed {
    logic             ok;
    logic             is_long;
    logic [SEC_W-1:0] sec;
  } pb_sound_t;
endpackage

// File: rtl/pb_rst_sync.sv
module pb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pb_tick_div.sv
module pb_tick_div #(
  parameter int TICK_DIV = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (en_i)  cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/pb_sound_map.sv
module pb_sound_map
  import pb_pkg::*;
#(
  parameter int NUM_SHORT = 4
) (
  input  logic [CODE_W-1:0] code_i,
  output pb_sound_t         snd_o
);
  localparam int NUM_LONG = ((1 << SEC_W) - NUM_SHORT) / 2;

  always_comb begin
    snd_o = '0;
    if (int'(code_i) < NUM_SHORT) begin
      snd_o.ok      = 1'b1;
      snd_o.is_long = 1'b0;
      snd_o.sec     = SEC_W'(code_i);
    end else if (int'(code_i) < NUM_SHORT + NUM_LONG) begin
      snd_o.ok      = 1'b1;
      snd_o.is_long = 1'b1;
      snd_o.sec     = SEC_W'(NUM_SHORT + 2 * (int'(code_i) - NUM_SHORT));
    end
  end
endmodule

// File: rtl/pb_seq.sv
module pb_seq
  import pb_pkg::*;
#(
  parameter int IDX_W = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 play_i,
  input  pb_sound_t            snd_i,
  input  logic                 tick_i,
  input  logic [BYTE_W-1:0]    rom_data_i,
  output logic [IDX_W+SEC_W:0] rom_addr_o,
  output logic [SAMPLE_W-1:0]  sample_o,
  output logic                 sample_vld_o,
  output logic                 busy_o,
  output logic                 start_o
);
  localparam int CNT_W  = IDX_W + 1;
  localparam int WORD_W = IDX_W + SEC_W;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'((1 << IDX_W) - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = {CNT_W{1'b1}};

  pb_state_e           state_q, state_d;
  logic [CNT_W-1:0]    idx_q, idx_d;
  logic [SEC_W-1:0]    sec_q, sec_d;
  logic                long_q, long_d;
  logic [BYTE_W-1:0]   lo_q, lo_d;
  logic [SAMPLE_W-1:0] smp_q, smp_d;
  logic                last_idx;
  logic [WORD_W-1:0]   word_addr;

  assign start_o   = play_i && snd_i.ok && (state_q == ST_IDLE);
  assign last_idx  = (idx_q == (long_q ? LAST_LONG : LAST_SHORT));
  assign word_addr = {sec_q, {IDX_W{1'b0}}} + WORD_W'(idx_q);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sec_d   = sec_q;
    long_d  = long_q;
    lo_d    = lo_q;
    smp_d   = smp_q;
    unique case (state_q)
      ST_IDLE: if (start_o) begin
        state_d = ST_WAIT;
        sec_d   = snd_i.sec;
        long_d  = snd_i.is_long;
        idx_d   = '0;
      end
      ST_WAIT: if (tick_i) state_d = ST_LO;
      ST_LO: begin
        lo_d    = rom_data_i;
        state_d = ST_HI;
      end
      ST_HI: begin
        smp_d   = {rom_data_i, lo_q};
        state_d = ST_EMIT;
      end
      ST_EMIT: begin
        if (last_idx) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end else begin
          state_d = ST_WAIT;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sec_q   <= '0;
      long_q  <= 1'b0;
      lo_q    <= '0;
      smp_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sec_q   <= sec_d;
      long_q  <= long_d;
      lo_q    <= lo_d;
      smp_q   <= smp_d;
    end
  end

  assign rom_addr_o   = {word_addr, (state_q == ST_HI)};
  assign sample_o     = smp_q;
  assign sample_vld_o = (state_q == ST_EMIT);
  assign busy_o       = (state_q != ST_IDLE);
endmodule

// File: rtl/rom_playback_seq.sv
module rom_playback_seq
  import pb_pkg::*;
#(
  parameter int TICK_DIV  = 3125,
  parameter int IDX_W     = 15,
  parameter int NUM_SHORT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 play_i,
  input  logic [2:0]           sound_i,
  output logic [IDX_W+3:0]     rom_addr_o,
  input  logic [7:0]           rom_data_i,
  output logic [15:0]          sample_o,
  output logic                 sample_vld_o,
  output logic                 busy_o
);
  logic      rst_sync_n;
  logic      tick;
  logic      start;
  pb_sound_t snd;

  pb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pb_sound_map #(.NUM_SHORT(NUM_SHORT)) u_map (
    .code_i (sound_i),
    .snd_o  (snd)
  );

  pb_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (start),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  pb_seq #(.IDX_W(IDX_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .play_i       (play_i),
    .snd_i        (snd),
    .tick_i       (tick),
    .rom_data_i   (rom_data_i),
    .rom_addr_o   (rom_addr_o),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o),
    .busy_o       (busy_o),
    .start_o      (start)
  );
endmodule

// File: rtl/rom_playback_seq_chk.sv
module rom_playback_seq_chk #(
  parameter int IDX_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             play_i,
  input logic [2:0]       sound_i,
  input logic [IDX_W+3:0] rom_addr_o,
  input logic [7:0]       rom_data_i,
  input logic [15:0]      sample_o,
  input logic             sample_vld_o,
  input logic             busy_o
);
  assert_vld_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |=> !sample_vld_o);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(play_i) && ($past(sound_i) < 3'd6)));

  assert_vld_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> busy_o);

  assert_stop_after_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(sample_vld_o));

  assert_byte_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> (!$past(rom_addr_o[0], 2) && $past(rom_addr_o[0])
                      && ($past(rom_addr_o) == $past(rom_addr_o, 2) + 1'b1)));

  assert_little_endian_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> ((sample_o[7:0] == $past(rom_data_i, 2))
                      && (sample_o[15:8] == $past(rom_data_i))));
endmodule

bind rom_playback_seq rom_playback_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .play_i       (play_i),
  .sound_i      (sound_i),
  .rom_addr_o   (rom_addr_o),
  .rom_data_i   (rom_data_i),
  .sample_o     (sample_o),
  .sample_vld_o (sample_vld_o),
  .busy_o       (busy_o)
);

// File: tb/sim_rom_playback_seq.sv
module sim_rom_playback_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 6;
  localparam int IW         = 2;
  localparam int AW         = IW + 4;
  localparam int SHORT_N    = 1 << IW;
  localparam int LONG_N     = 1 << (IW + 1);
  localparam int WD_LIMIT   = 20000;

  logic          clk;
  logic          rst_n;
  logic          play;
  logic [2:0]    sound;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;
  logic [15:0]   sample;
  logic          vld;
  logic          busy;

  int errors;
  int checks;
  int cyc;
  bit done;
  logic [15:0] expq[$];

  rom_playback_seq #(.TICK_DIV(DIV), .IDX_W(IW), .NUM_SHORT(4)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .play_i       (play),
    .sound_i      (sound),
    .rom_addr_o   (rom_addr),
    .rom_data_i   (rom_data),
    .sample_o     (sample),
    .sample_vld_o (vld),
    .busy_o       (busy)
  );

  function automatic logic [7:0] rom_byte(input int a);
    return 8'((a * 29 + 7) ^ (a >> 2) * 91);
  endfunction

  assign rom_data = rom_byte(int'(rom_addr));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard and checks spacing and stop timing.
  bit prev_vld;
  bit have_prev;
  int last_vld_cyc;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!busy) have_prev = 0;
      if (vld) begin
        if (expq.size() == 0) begin
          check(0, "R9/R10 unexpected sample", int'(sample), 0);
        end else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(sample == e, "R4/R7/R8 sample", int'(sample), int'(e));
        end
        if (have_prev) check(cyc - last_vld_cyc == DIV, "R5 spacing", cyc - last_vld_cyc, DIV);
        have_prev = 1;
        last_vld_cyc = cyc;
      end
      if (prev_vld) begin
        check(!vld, "R5 pulse width", int'(vld), 0);
        if (expq.size() == 0) check(!busy, "R11 busy clears", int'(busy), 0);
        else                  check(busy, "R11 busy held", int'(busy), 1);
      end
      prev_vld = vld;
    end
  end

  function automatic int sec_of(input int code);
    if (code < 4) return code;
    return 4 + 2 * (code - 4);
  endfunction

  task automatic push_sound(input int code);
    int n;
    n = (code < 4) ? SHORT_N : LONG_N;
    for (int k = 0; k < n; k++) begin
      int lo;
      lo = ((sec_of(code) << IW) + k) * 2;
      expq.push_back({rom_byte(lo + 1), rom_byte(lo)});
    end
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(expq.size() == 0, "R7/R8 sample count", expq.size(), 0);
    @(negedge clk);
  endtask

  // Driver: R2 R6 plus start of each sound.
  task automatic play_sound(input int code);
    bit accept;
    accept = !busy && code < 6;
    play  = 1'b1;
    sound = 3'(code);
    if (accept) push_sound(code);
    @(negedge clk);
    play = 1'b0;
    if (accept) begin
      check(busy, "R2 busy after accept", int'(busy), 1);
      repeat (DIV + 1) @(negedge clk);
      check(!vld, "R6 not early", int'(vld), 0);
      @(negedge clk);
      check(vld, "R6 first sample time", int'(vld), 1);
    end
  endtask

  initial begin
    errors = 0; checks = 0; cyc = 0; done = 0;
    prev_vld = 0; have_prev = 0; last_vld_cyc = 0;
    play = 1'b0; sound = 3'd0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !vld, "R1 reset outputs", int'({busy, vld}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !vld, "R1 after release", int'({busy, vld}), 0);

    for (int c = 0; c < 6; c++) begin
      play_sound(c);
      wait_idle();
    end

    // R11: replay restarts from index 0
    play_sound(4);
    wait_idle();

    // R9: request mid-sound is ignored
    play_sound(2);
    repeat (DIV) @(negedge clk);
    play_sound(5);
    check(busy, "R9 still running", int'(busy), 1);
    wait_idle();

    // R10: unused codes ignored
    for (int c = 6; c < 8; c++) begin
      play_sound(c);
      check(!busy, "R10 no start", int'(busy), 0);
      repeat (3 * DIV) @(negedge clk);
      check(!busy, "R10 still idle", int'(busy), 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0 cycles left", WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule